// File: doc/BRIEF.md
# Oscillator Edge-Tracing Tap Selector

This block turns the edge train of a ring oscillator that runs only during one half of a reference period into a single traced pulse. The pulse marks the third-from-last oscillator rising edge of that half-period. The oscillator edges arrive as a one-cycle strobe on a fast sample clock, and the gating half-period arrives as a level. Each strobe seen while the gate is high advances a short cyclic tap chain. Each time the chain wraps past its last tap, a saturating group counter increments. When the gate falls, the block records the tap reached by the last edge and the number of completed groups.

In the following window, the recorded tap and group count decide which later edge is forwarded. The forwarded tap is two positions behind the recorded tap, taken cyclically. It is passed on only when the live group count, plus a correction of 0 or 1 that depends on the recorded tap, equals the stored group count. As a result, exactly the last pulse on that tap is passed out. A neighbour-tolerant filter keeps the recorded tap from flickering by one position from window to window. One instance serves one half of the reference period, so a full tracer uses two instances with opposite gate polarity.

Top module: `gro_edge_tracer`

## Requirements
- R1: After a synchronous active-low reset, `sel_o`, `cnt_o`, `trace_o`, `nopulse_o` and `range_o` are all zero.
- R2: A strobe on `osc_edge_i` is counted only while `gate_i` is high. Strobes while the gate is low do not change the results of any later window.
- R3: The falling edge of `gate_i` ends a window. Edge number e (1-based) in a window hits tap ((e-1) mod 5)+1. If the previous select is zero, or is not adjacent to the new last tap, `sel_o` becomes one-hot with bit t-1 set, where t is the tap of the window's last edge j. The outputs are valid from the first clock after the gate falls.
- R4: The previous select is kept when the new last tap is the same tap or the tap directly above or below it. Neighbours are not cyclic: taps 1 and 5 are not neighbours.
- R5: A window with no edges leaves `sel_o` and `cnt_o` unchanged and sets `nopulse_o`. Any window with edges clears `nopulse_o`.
- R6: At the end of a window with j edges, `cnt_o` becomes floor(j/5), saturating at 63. `range_o` is 1 exactly when an increment was refused at 63, that is when j is at least 320.
- R7: During a window, edge e is forwarded when all three of these hold: its tap equals ((s+2) mod 5)+1, where s is the stored tap; min(floor((e-1)/5),63)+d equals the stored `cnt_o`; and d is 1 for s in {1,2,5} and 0 for s in {3,4}. When the period is steady, this is edge j-2 of the previous window.
- R8: A forwarded edge gives a one-cycle high on `trace_o` on the clock after its strobe is sampled. There is at most one such pulse per window, and no pulse while the stored select is zero.
- R9: The live tap position and group count restart at zero in every window, so each window's results depend only on its own edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_i | input | 1 | Oscillator enable level; a high level is one window |
| osc_edge_i | input | 1 | One-cycle strobe per oscillator rising edge |
| sel_o | output | NTAPS | One-hot stored last tap, bit t-1 for tap t |
| cnt_o | output | CNT_W | Stored completed-group count |
| trace_o | output | 1 | Traced output pulse |
| nopulse_o | output | 1 | Last window saw no edges |
| range_o | output | 1 | Last window overflowed the group counter |

## Verification
The bench builds the block with its defaults: five taps and a 6-bit group counter. With these values saturation needs only about 330 edges, so a directed window of a few hundred cycles can reach the out-of-range flag and the capped compare. The random windows of 0 to 40 edges cover every last-tap residue, the short windows where no trace is possible, and the adjacent-tap filter cases. Directed windows pin down the hold cases of the filter and strobes that arrive while the gate is low.

// File: rtl/edge_trace_pkg.sv
// Package: shared tap-arithmetic helpers for the edge tracer.
// Assumes taps are numbered 1..n and that n is at least 3.
package edge_trace_pkg;

    // Tap that carries the edge two positions before the given last tap.
    function automatic int unsigned fwd_tap(input int unsigned last, input int unsigned n);
        return ((last + n - 3) % n) + 1;
    endfunction

    // 1 when the forwarded edge falls in the group before the last one.
    function automatic logic needs_sub(input int unsigned last, input int unsigned n);
        return (last <= 2) || (last == n);
    endfunction

endpackage

// File: rtl/et_tap_chain.sv
// Module: cyclic tap chain plus saturating group counter.
// Counts oscillator strobes while the gate is high. The position runs
// 1..NTAPS, and the counter increments when the position reaches NTAPS.
// A clear pulse at window end returns everything to zero.
module et_tap_chain #(
    parameter int NTAPS = 5,
    parameter int CNT_W = 6,
    localparam int PH_W = $clog2(NTAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             edge_i,
    input  logic             clear_i,
    output logic [PH_W-1:0]  ph_o,
    output logic [PH_W-1:0]  ph_nxt_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o,
    output logic             step_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(NTAPS);

    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sat_q;

    // Next tap position: wrap to tap 1 after the last tap.
    always_comb ph_nxt_o = (ph_q == PH_TOP) ? PH_W'(1) : ph_q + PH_W'(1);

    assign step_o = gate_i & edge_i;

    // Advance the chain and the group counter on a gated strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ph_q  <= '0;
            cnt_q <= '0;
            sat_q <= 1'b0;
        end else if (step_o) begin
            ph_q <= ph_nxt_o;
            if (ph_nxt_o == PH_TOP) begin
                if (cnt_q == CNT_MAX) sat_q <= 1'b1;
                else                  cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign ph_o  = ph_q;
    assign cnt_o = cnt_q;
    assign sat_o = sat_q;

    assert_ph_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_TOP);
    assert_gate_low_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !clear_i) |=> $stable(ph_q));
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (ph_q == '0 && cnt_q == '0 && !sat_q));
endmodule

// File: rtl/et_path_filter.sv
// Module: thermometer-to-one-hot decode and a neighbour-tolerant select.
// At window end the tap position becomes a thermometer code, then a
// one-hot last tap. The stored select is kept when the new tap equals it
// or is directly adjacent to it; an empty window holds the select.
module et_path_filter #(
    parameter int NTAPS = 5,
    localparam int PH_W = $clog2(NTAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end_i,
    input  logic [PH_W-1:0]  ph_i,
    output logic [NTAPS-1:0] sel_o,
    output logic             empty_o,
    output logic             nopulse_o
);
    logic [NTAPS-1:0] therm;
    logic [NTAPS-1:0] s_vec;
    logic [NTAPS-1:0] near;
    logic [NTAPS-1:0] sel_q;
    logic             nop_q;
    logic             keep;

    genvar gi;
    generate
        for (gi = 0; gi < NTAPS; gi++) begin : g_tap
            assign therm[gi] = (ph_i >= PH_W'(gi + 1));
            if (gi == NTAPS - 1) begin : g_top
                assign s_vec[gi] = therm[gi];
            end else begin : g_mid
                assign s_vec[gi] = therm[gi] & ~therm[gi+1];
            end
            if (gi == 0) begin : g_lo
                assign near[gi] = s_vec[gi] | s_vec[gi+1];
            end else if (gi == NTAPS - 1) begin : g_hi
                assign near[gi] = s_vec[gi-1] | s_vec[gi];
            end else begin : g_in
                assign near[gi] = s_vec[gi-1] | s_vec[gi] | s_vec[gi+1];
            end
        end
    endgenerate

    assign empty_o = ~|s_vec;
    assign keep    = |(sel_q & near);

    // Update the stored select and the no-edge flag at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            nop_q <= 1'b0;
        end else if (win_end_i) begin
            nop_q <= empty_o;
            if (!empty_o && !keep) sel_q <= s_vec;
        end
    end

    assign sel_o     = sel_q;
    assign nopulse_o = nop_q;

    assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_q));
    assert_empty_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && empty_o) |=> $stable(sel_q));
    assert_neighbour_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && keep) |=> $stable(sel_q));
endmodule

// File: rtl/et_last_pulse_gate.sv
// Module: stored group count and the subtract-and-compare last-pulse gate.
// Assumes sel_i is one-hot or zero. It forwards the strobe whose new
// position equals the forwarded tap and whose live count plus the
// correction equals the count stored at the previous window end.
module et_last_pulse_gate
    import edge_trace_pkg::*;
#(
    parameter int NTAPS = 5,
    parameter int CNT_W = 6,
    localparam int PH_W = $clog2(NTAPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             win_end_i,
    input  logic             empty_i,
    input  logic [NTAPS-1:0] sel_i,
    input  logic             step_i,
    input  logic [PH_W-1:0]  ph_nxt_i,
    input  logic [CNT_W-1:0] cnt_live_i,
    input  logic             sat_live_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             range_o,
    output logic             trace_o
);
    logic [CNT_W-1:0] cnt_st_q;
    logic             range_q;
    logic             trace_q;
    logic [PH_W-1:0]  fwd_idx;
    logic             sub;
    logic             hit;

    // Decode the forwarded tap and the subtrahend from the stored select.
    always_comb begin
        fwd_idx = '0;
        sub     = 1'b0;
        for (int i = 0; i < NTAPS; i++) begin
            if (sel_i[i]) begin
                fwd_idx = PH_W'(fwd_tap(i + 1, NTAPS));
                sub     = needs_sub(i + 1, NTAPS);
            end
        end
    end

    // Match when the strobe reaches the forwarded tap in the target group.
    always_comb hit = step_i && (|sel_i) && (ph_nxt_i == fwd_idx) &&
                      (({1'b0, cnt_live_i} + {{CNT_W{1'b0}}, sub}) == {1'b0, cnt_st_q});

    // Hold the stored count and range flag; register the traced pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_st_q <= '0;
            range_q  <= 1'b0;
            trace_q  <= 1'b0;
        end else begin
            trace_q <= hit;
            if (win_end_i) begin
                range_q <= sat_live_i;
                if (!empty_i) cnt_st_q <= cnt_live_i;
            end
        end
    end

    assign cnt_o   = cnt_st_q;
    assign range_o = range_q;
    assign trace_o = trace_q;

    assert_trace_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trace_q |-> $past(gate_i));
    assert_trace_needs_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trace_q |-> $past(|sel_i));
    assert_trace_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trace_q |=> !trace_q);
endmodule

// File: rtl/gro_edge_tracer.sv
// Module: top of the gated-oscillator edge tracer for one half-period.
// Detects window end from the falling gate and ties together the tap
// chain, the select filter and the last-pulse gate. All state is on clk.
module gro_edge_tracer #(
    parameter int NTAPS = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             osc_edge_i,
    output logic [NTAPS-1:0] sel_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             trace_o,
    output logic             nopulse_o,
    output logic             range_o
);
    localparam int PH_W = $clog2(NTAPS + 1);

    logic             gate_q;
    logic             win_end;
    logic [PH_W-1:0]  ph;
    logic [PH_W-1:0]  ph_nxt;
    logic [CNT_W-1:0] cnt_live;
    logic             sat_live;
    logic             step;
    logic             empty;
    logic [NTAPS-1:0] sel;

    // Delay the gate by one clock to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_i;
    end

    assign win_end = gate_q & ~gate_i;

    et_tap_chain #(.NTAPS(NTAPS), .CNT_W(CNT_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .edge_i(osc_edge_i),
        .clear_i(win_end), .ph_o(ph), .ph_nxt_o(ph_nxt), .cnt_o(cnt_live),
        .sat_o(sat_live), .step_o(step)
    );

    et_path_filter #(.NTAPS(NTAPS)) u_filter (
        .clk(clk), .rst_n(rst_n), .win_end_i(win_end), .ph_i(ph),
        .sel_o(sel), .empty_o(empty), .nopulse_o(nopulse_o)
    );

    et_last_pulse_gate #(.NTAPS(NTAPS), .CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .win_end_i(win_end),
        .empty_i(empty), .sel_i(sel), .step_i(step), .ph_nxt_i(ph_nxt),
        .cnt_live_i(cnt_live), .sat_live_i(sat_live), .cnt_o(cnt_o),
        .range_o(range_o), .trace_o(trace_o)
    );

    assign sel_o = sel;

    assert_nopulse_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (nopulse_o == $past(empty)));
endmodule

// File: tb/tb_gro_edge_tracer.sv
module tb_gro_edge_tracer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate = 1'b0;
    logic       strobe = 1'b0;
    logic [4:0] sel_o;
    logic [5:0] cnt_o;
    logic       trace_o, nopulse_o, range_o;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_idx = 0;
    int tr_cnt = 0;
    int tr_at = 0;
    int exp_sel = 0;
    int exp_n = 0;
    int exp_nop = 0;

    always #10 clk = ~clk;

    gro_edge_tracer dut (
        .clk(clk), .rst_n(rst_n), .gate_i(gate), .osc_edge_i(strobe),
        .sel_o(sel_o), .cnt_o(cnt_o), .trace_o(trace_o),
        .nopulse_o(nopulse_o), .range_o(range_o)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int sel_idx(input logic [4:0] v);
        int r = 0;
        int n = 0;
        for (int i = 0; i < 5; i++) if (v[i]) begin r = i + 1; n++; end
        return (n > 1) ? 99 : r;
    endfunction

    // One clock: observe trace from the previous strobe, then drive.
    task automatic step(input logic g, input logic s, input int idx);
        @(negedge clk);
        if (trace_o) begin tr_cnt++; tr_at = prev_idx; end
        gate = g; strobe = s;
        prev_idx = s ? idx : 0;
    endtask

    task automatic run_window(input int j, input string tag);
        int et = 0, ec = 0, lt, sub, fwd, bef;
        int a, b;
        // Expected trace from the state stored before this window (R7).
        if (exp_sel != 0) begin
            sub = (exp_sel <= 2 || exp_sel == 5) ? 1 : 0;
            fwd = ((exp_sel + 2) % 5) + 1;
            for (int e = 1; e <= j; e++) begin
                bef = (e - 1) / 5; if (bef > 63) bef = 63;
                if (((e - 1) % 5) + 1 == fwd && bef + sub == exp_n) begin et = e; ec++; end
            end
        end
        tr_cnt = 0; tr_at = 0;
        step(1, 0, 0);
        for (int e = 1; e <= j; e++) begin
            step(1, 1, e);
            for (int g = 0; g < int'($urandom_range(2, 0)); g++) step(1, 0, 0);
        end
        step(1, 0, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        // Update expected stored state (R3 to R6).
        lt = (j == 0) ? 0 : ((j - 1) % 5) + 1;
        exp_nop = (j == 0);
        if (j != 0) begin
            a = lt - exp_sel; if (a < 0) a = -a;
            if (!(exp_sel != 0 && a <= 1)) exp_sel = lt;
            b = j / 5; exp_n = (b > 63) ? 63 : b;
        end
        chk({"R7/R8 trace count ", tag}, tr_cnt, ec);
        chk({"R7 traced edge ", tag}, tr_at, et);
        chk({"R3/R4 sel ", tag}, sel_idx(sel_o), exp_sel);
        chk({"R6 count ", tag}, cnt_o, exp_n);
        chk({"R5 nopulse ", tag}, nopulse_o, exp_nop);
        chk({"R6 range ", tag}, range_o, ((j / 5) > 63) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel", sel_o, 0);
        chk("R1 cnt", cnt_o, 0);
        chk("R1 trace", trace_o, 0);
        chk("R1 nopulse", nopulse_o, 0);
        chk("R1 range", range_o, 0);
        rst_n = 1'b1;
        step(0, 0, 0);
        // R5 empty window with nothing stored
        run_window(0, "empty-initial");
        // R3 first load, R9 fresh start
        run_window(13, "load-13");
        // R4 neighbour above keeps tap 3; R7 trace at edge 11
        run_window(14, "neighbour-14");
        // R4 non-neighbour reloads
        run_window(11, "reload-11");
        // R2 strobes with gate low are ignored
        for (int k = 0; k < 7; k++) step(0, 1, 0);
        step(0, 0, 0);
        run_window(7, "after-stray-R2");
        // R5 empty window holds sel and count
        run_window(0, "empty-hold");
        // short windows with no possible trace
        run_window(1, "one");
        run_window(2, "two");
        run_window(10, "ten");
        // R4 taps 1 and 5 are not neighbours
        run_window(15, "wrap-15");
        run_window(16, "wrap-16");
        // R6 saturation and out-of-range flag
        run_window(330, "saturate");
        run_window(12, "post-sat");
        // random windows, R9 independence across windows
        for (int w = 0; w < 40; w++) run_window(int'($urandom_range(40, 0)), "random");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule